// File: doc/BRIEF.md
# Predicated Vector Leading-Zero Counter

This block executes a vector count-leading-zeros operation on a 128-bit register value in one clock. It decodes a 32-bit instruction word and takes a source vector, the current contents of the destination register and a per-byte write-enable mask. The element-size field of the instruction splits the source into sixteen 8-bit lanes, eight 16-bit lanes or four 32-bit lanes. Each lane is replaced by the number of zero bits above its most significant set bit. A lane of all zeros yields the lane width.

Results are merged into the old destination value one byte at a time. Each byte follows its own mask bit, whatever the element size, so a wide lane can be partly written. The decoder also outputs the two register indices and flags encodings that cannot execute: a reserved size, a register outside the eight implemented ones, or a word that does not match the operation's fixed bits. A flagged instruction leaves the destination value unchanged. The surrounding pipeline supplies the operands and writes the result back.

Top module: `vclz_unit`

## Requirements
- R1: With size bits 19:18 equal to 0, each of the 16 byte lanes of `out_vec` holds the leading-zero count of the matching source byte.
- R2: With size code 1, each of the 8 16-bit lanes holds the leading-zero count of the matching 16-bit source lane, zero-extended to 16 bits.
- R3: With size code 2, each of the 4 32-bit lanes holds the leading-zero count of the matching 32-bit source lane.
- R4: A lane whose source bits are all zero returns its width: 8, 16 or 32.
- R5: Byte k of `out_vec` takes the new result only when `byte_mask[k]` is 1 and otherwise equals byte k of `dst_vec`. This holds even when only some bytes of one lane are enabled.
- R6: Lanes are little-endian: lane e of width W occupies bits e*W to e*W+W-1, and uses mask bits e*W/8 up to (e+1)*W/8-1.
- R7: `out_dst_idx` is {instr[22], instr[15:13]} and `out_src_idx` is {instr[5], instr[3:1]}, both taken from the accepted word.
- R8: Size code 3 sets `out_undef`, and `out_vec` then equals `dst_vec`.
- R9: A word for which (instr & 32'hFFB31FD1) != 32'hFFB004C0 sets `out_undef` and passes `dst_vec` through unchanged.
- R10: If instr[22] or instr[5] is 1 (a register index of 8 or above), `out_undef` is set and `dst_vec` passes through unchanged.
- R11: `out_valid` is 1 exactly in the cycle after a cycle with `in_valid` high. Reset clears `out_valid`, `out_undef` and `out_vec` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and instruction present this cycle |
| instr | input | 32 | Instruction word |
| src_vec | input | 128 | Source vector value |
| dst_vec | input | 128 | Current destination vector value |
| byte_mask | input | 16 | Per-byte write enable, bit k for byte k |
| out_valid | output | 1 | Registered result valid |
| out_vec | output | 128 | Merged destination value |
| out_undef | output | 1 | Instruction was not executable |
| out_dst_idx | output | 4 | Decoded destination register index |
| out_src_idx | output | 4 | Decoded source register index |

## Verification
The checker's properties assume that `dst_vec`, `byte_mask` and the instruction fields are sampled only in cycles where `in_valid` is high. They also assume that a result belongs to the inputs of the previous cycle. The bench respects this by changing inputs only on falling edges and by pulsing `in_valid` for single cycles, with idle cycles between operations. Reserved sizes, high register bits and corrupted fixed bits are each applied on their own. This way every undefined-flag check traces to one cause.

// File: rtl/vclz_pkg.sv
package vclz_pkg;
  typedef enum logic [1:0] {
    ESZ_BYTE = 2'd0,
    ESZ_HALF = 2'd1,
    ESZ_WORD = 2'd2,
    ESZ_RSVD = 2'd3
  } elem_size_e;

  localparam logic [31:0] OP_CARE  = 32'hFFB3_1FD1;
  localparam logic [31:0] OP_MATCH = 32'hFFB0_04C0;
  localparam int unsigned REG_IDX_W = 4;
  localparam int unsigned NUM_SIZES = 3;
endpackage

// File: rtl/vclz_decode.sv
module vclz_decode
  import vclz_pkg::*;
(
  input  logic [31:0]          instr,
  output logic [REG_IDX_W-1:0] dst_idx,
  output logic [REG_IDX_W-1:0] src_idx,
  output elem_size_e           esize,
  output logic                 undef
);
  logic pattern_ok;
  logic reg_high;

  always_comb begin
    dst_idx    = {instr[22], instr[15:13]};
    src_idx    = {instr[5], instr[3:1]};
    esize      = elem_size_e'(instr[19:18]);
    pattern_ok = ((instr & OP_CARE) == OP_MATCH);
    reg_high   = dst_idx[REG_IDX_W-1] | src_idx[REG_IDX_W-1];
    undef      = !pattern_ok || (esize == ESZ_RSVD) || reg_high;
  end
endmodule

// File: rtl/vclz_lane_count.sv
module vclz_lane_count #(
  parameter int unsigned LANE_W = 8,
  localparam int unsigned CNT_W = $clog2(LANE_W + 1)
) (
  input  logic [LANE_W-1:0] lane,
  output logic [CNT_W-1:0]  count
);
  always_comb begin
    count = CNT_W'(LANE_W);
    for (int i = 0; i < LANE_W; i++) begin
      if (lane[i]) count = CNT_W'(LANE_W - 1 - i);
    end
  end
endmodule

// File: rtl/vclz_lane_group.sv
module vclz_lane_group #(
  parameter int unsigned VEC_W  = 128,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned NLANES = VEC_W / LANE_W,
  localparam int unsigned CNT_W  = $clog2(LANE_W + 1)
) (
  input  logic [VEC_W-1:0] src,
  output logic [VEC_W-1:0] counts
);
  for (genvar e = 0; e < NLANES; e++) begin : g_lane
    logic [CNT_W-1:0] cnt;
    vclz_lane_count #(.LANE_W(LANE_W)) u_cnt (
      .lane  (src[e*LANE_W +: LANE_W]),
      .count (cnt)
    );
    assign counts[e*LANE_W +: LANE_W] = {{(LANE_W-CNT_W){1'b0}}, cnt};
  end
endmodule

// File: rtl/vclz_byte_merge.sv
module vclz_byte_merge #(
  parameter int unsigned VEC_W = 128,
  localparam int unsigned NBYTES = VEC_W / 8
) (
  input  logic [VEC_W-1:0]  new_vec,
  input  logic [VEC_W-1:0]  old_vec,
  input  logic [NBYTES-1:0] mask,
  input  logic              enable,
  output logic [VEC_W-1:0]  merged
);
  for (genvar k = 0; k < NBYTES; k++) begin : g_byte
    assign merged[k*8 +: 8] = (enable && mask[k]) ? new_vec[k*8 +: 8] : old_vec[k*8 +: 8];
  end
endmodule

// File: rtl/vclz_unit.sv
module vclz_unit
  import vclz_pkg::*;
#(
  parameter int unsigned VEC_W = 128,
  localparam int unsigned NBYTES = VEC_W / 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [31:0]          instr,
  input  logic [VEC_W-1:0]     src_vec,
  input  logic [VEC_W-1:0]     dst_vec,
  input  logic [NBYTES-1:0]    byte_mask,
  output logic                 out_valid,
  output logic [VEC_W-1:0]     out_vec,
  output logic                 out_undef,
  output logic [REG_IDX_W-1:0] out_dst_idx,
  output logic [REG_IDX_W-1:0] out_src_idx
);
  logic [REG_IDX_W-1:0] dec_dst;
  logic [REG_IDX_W-1:0] dec_src;
  elem_size_e           dec_size;
  logic                 dec_undef;
  logic [VEC_W-1:0]     group_res [NUM_SIZES];
  logic [VEC_W-1:0]     sel_res;
  logic [VEC_W-1:0]     merged;

  vclz_decode u_dec (
    .instr   (instr),
    .dst_idx (dec_dst),
    .src_idx (dec_src),
    .esize   (dec_size),
    .undef   (dec_undef)
  );

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
    vclz_lane_group #(.VEC_W(VEC_W), .LANE_W(8 << g)) u_grp (
      .src    (src_vec),
      .counts (group_res[g])
    );
  end

  always_comb begin
    case (dec_size)
      ESZ_BYTE: sel_res = group_res[0];
      ESZ_HALF: sel_res = group_res[1];
      ESZ_WORD: sel_res = group_res[2];
      default:  sel_res = dst_vec;
    endcase
  end

  vclz_byte_merge #(.VEC_W(VEC_W)) u_merge (
    .new_vec (sel_res),
    .old_vec (dst_vec),
    .mask    (byte_mask),
    .enable  (!dec_undef),
    .merged  (merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_vec     <= '0;
      out_undef   <= 1'b0;
      out_dst_idx <= '0;
      out_src_idx <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_vec     <= merged;
        out_undef   <= dec_undef;
        out_dst_idx <= dec_dst;
        out_src_idx <= dec_src;
      end
    end
  end
endmodule

// File: rtl/vclz_unit_checker.sv
module vclz_unit_checker #(
  parameter int unsigned VEC_W = 128,
  localparam int unsigned NBYTES = VEC_W / 8
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [3:0]        fld_dst,
  input logic [3:0]        fld_src,
  input logic [1:0]        fld_size,
  input logic [VEC_W-1:0]  dst_vec,
  input logic [NBYTES-1:0] byte_mask,
  input logic              out_valid,
  input logic [VEC_W-1:0]  out_vec,
  input logic              out_undef,
  input logic [3:0]        out_dst_idx,
  input logic [3:0]        out_src_idx
);
  a_r11_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  a_r8_rsvd_size: assert property (@(posedge clk) disable iff (rst)
    (in_valid && fld_size == 2'd3) |=> out_undef);
  a_r10_high_reg: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (fld_dst[3] || fld_src[3])) |=> out_undef);
  a_r8_undef_passthrough: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_undef) |-> (out_vec == $past(dst_vec)));
  a_r7_indices: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_dst_idx == $past(fld_dst) && out_src_idx == $past(fld_src)));
  for (genvar k = 0; k < NBYTES; k++) begin : g_hold
    a_r5_masked_byte_holds: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !$past(byte_mask[k])) |-> (out_vec[k*8 +: 8] == $past(dst_vec[k*8 +: 8])));
  end
endmodule

bind vclz_unit vclz_unit_checker #(.VEC_W(VEC_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .fld_dst     ({instr[22], instr[15:13]}),
  .fld_src     ({instr[5], instr[3:1]}),
  .fld_size    (instr[19:18]),
  .dst_vec     (dst_vec),
  .byte_mask   (byte_mask),
  .out_valid   (out_valid),
  .out_vec     (out_vec),
  .out_undef   (out_undef),
  .out_dst_idx (out_dst_idx),
  .out_src_idx (out_src_idx)
);

// File: tb/vclz_unit_tb.sv
`timescale 1ns/1ps
module vclz_unit_tb;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [31:0]  instr = '0;
  logic [127:0] src_vec = '0;
  logic [127:0] dst_vec = '0;
  logic [15:0]  byte_mask = '0;
  logic         out_valid;
  logic [127:0] out_vec;
  logic         out_undef;
  logic [3:0]   out_dst_idx;
  logic [3:0]   out_src_idx;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vclz_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .src_vec(src_vec), .dst_vec(dst_vec), .byte_mask(byte_mask),
    .out_valid(out_valid), .out_vec(out_vec), .out_undef(out_undef),
    .out_dst_idx(out_dst_idx), .out_src_idx(out_src_idx)
  );

  function automatic logic [31:0] enc(input logic [3:0] qd, input logic [3:0] qm, input logic [1:0] sz);
    enc = 32'hFFB004C0 | (32'(qd[3]) << 22) | (32'(qd[2:0]) << 13) |
          (32'(sz) << 18) | (32'(qm[3]) << 5) | (32'(qm[2:0]) << 1);
  endfunction

  function automatic logic [127:0] model(input logic [127:0] s, input logic [127:0] d,
                                         input logic [15:0] m, input int w);
    logic [127:0] r;
    r = '0;
    for (int e = 0; e < 128 / w; e++) begin
      int  cnt;
      bit  found;
      cnt = 0;
      found = 0;
      for (int i = w - 1; i >= 0; i--) begin
        if (!found) begin
          if (s[e*w + i]) found = 1;
          else cnt++;
        end
      end
      for (int i = 0; i < 8; i++) r[e*w + i] = cnt[i];
    end
    for (int k = 0; k < 16; k++)
      if (!m[k]) r[k*8 +: 8] = d[k*8 +: 8];
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // one operation: drive on falling edge, result sampled one falling edge later
  task automatic run_op(input string req, input logic [31:0] iw, input logic [127:0] s,
                        input logic [127:0] d, input logic [15:0] m,
                        input bit exp_undef, input int w);
    logic [127:0] exp_vec;
    exp_vec = exp_undef ? d : model(s, d, m, w);
    @(negedge clk);
    in_valid = 1'b1; instr = iw; src_vec = s; dst_vec = d; byte_mask = m;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1, req, "out_valid", 128'(out_valid), 128'd1);
    check(out_undef === exp_undef, req, "out_undef", 128'(out_undef), 128'(exp_undef));
    check(out_vec === exp_vec, req, "out_vec", out_vec, exp_vec);
    check(out_dst_idx === {iw[22], iw[15:13]} && out_src_idx === {iw[5], iw[3:1]}, "R7",
          "indices", 128'({out_dst_idx, out_src_idx}), 128'({iw[22], iw[15:13], iw[5], iw[3:1]}));
    @(negedge clk);
    check(out_valid === 1'b0, "R11", "idle out_valid", 128'(out_valid), 128'd0);
  endtask

  task automatic t_reset;
    check(out_valid === 1'b0 && out_undef === 1'b0 && out_vec === '0, "R11", "reset state",
          {126'(out_vec), out_valid, out_undef}, 128'd0);
  endtask

  task automatic t_bytes; // R1, R6
    run_op("R1", enc(4'd1, 4'd2, 2'd0), 128'h80_40_20_10_08_04_02_01_FF_7F_3F_1F_0F_07_03_01,
           128'h0, 16'hFFFF, 1'b0, 8);
    run_op("R6", enc(4'd7, 4'd0, 2'd0), 128'h01_00_00_00_00_00_00_00_00_00_00_00_00_00_00_80,
           128'hDEAD, 16'hFFFF, 1'b0, 8);
  endtask

  task automatic t_halves; // R2
    run_op("R2", enc(4'd3, 4'd4, 2'd1), 128'h8000_4000_0100_0080_0010_0001_FFFF_0003,
           128'h0, 16'hFFFF, 1'b0, 16);
  endtask

  task automatic t_words; // R3, R6
    run_op("R3", enc(4'd5, 4'd6, 2'd2), 128'h80000000_00010000_00000100_00000001,
           128'h0, 16'hFFFF, 1'b0, 32);
  endtask

  task automatic t_zero_lanes; // R4
    run_op("R4", enc(4'd0, 4'd1, 2'd0), 128'h0, 128'h0, 16'hFFFF, 1'b0, 8);
    run_op("R4", enc(4'd0, 4'd1, 2'd1), 128'h0, 128'h0, 16'hFFFF, 1'b0, 16);
    run_op("R4", enc(4'd0, 4'd1, 2'd2), 128'h0, 128'h0, 16'hFFFF, 1'b0, 32);
  endtask

  task automatic t_partial_mask; // R5
    logic [127:0] d;
    d = 128'hA5A5A5A5_5A5A5A5A_C3C3C3C3_3C3C3C3C;
    run_op("R5", enc(4'd2, 4'd3, 2'd2), 128'h0, d, 16'b0001_0011_0110_1000, 1'b0, 32);
    run_op("R5", enc(4'd2, 4'd3, 2'd1), 128'h00010002_00040008_00100020_00400080, d,
           16'b1010_0101_1100_0011, 1'b0, 16);
    run_op("R5", enc(4'd2, 4'd3, 2'd0), 128'h0, d, 16'h0000, 1'b0, 8);
  endtask

  task automatic t_rsvd_size; // R8
    run_op("R8", enc(4'd1, 4'd1, 2'd3), 128'h0, 128'h1234_5678, 16'hFFFF, 1'b1, 8);
  endtask

  task automatic t_bad_pattern; // R9
    run_op("R9", enc(4'd1, 4'd2, 2'd0) ^ 32'h0000_0001, 128'h0, 128'hCAFE, 16'hFFFF, 1'b1, 8);
    run_op("R9", enc(4'd1, 4'd2, 2'd2) ^ 32'h0100_0000, 128'h0, 128'hBEEF, 16'hFFFF, 1'b1, 8);
  endtask

  task automatic t_high_reg; // R10
    run_op("R10", enc(4'd9, 4'd2, 2'd0), 128'h0, 128'h55, 16'hFFFF, 1'b1, 8);
    run_op("R10", enc(4'd1, 4'd12, 2'd1), 128'h0, 128'h66, 16'hFFFF, 1'b1, 8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_bytes();
    t_halves();
    t_words();
    t_zero_lanes();
    t_partial_mask();
    t_rsvd_size();
    t_bad_pattern();
    t_high_reg();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule